// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital half of an N-bit successive-approximation converter. It drives a trial code onto an external DAC and reads back one comparator bit, `cmp_above`, which is high when the DAC output is greater than the analog input. A conversion finds the input one bit at a time, starting at the most significant bit and ending at the least significant bit. Each bit is first set in the trial code. One clock later the comparator is sampled, and the bit is either removed or kept.

The controller has two named states. `ST_IDLE` holds the trial code at zero, so the DAC sees all zeros between conversions. `ST_TEST` is the bit-by-bit search. There are three transitions:

- IDLE→TEST (`load`): taken when `start` is high in `ST_IDLE`.
- TEST→TEST (`step`): taken while the bit under test is not bit 0.
- TEST→IDLE (`finish`): taken on the decision for bit 0.

On `finish` the code is copied into a separate result register and `done` is raised. Both hold until the next accepted start.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset `trial_code`, `result`, `done` and `busy` are all zero.
- R2: A clock edge that finds `start` high in the idle state makes `trial_code` exactly the most significant bit alone (1 followed by WIDTH-1 zeros), raises `busy` and clears `done`.
- R3: On each edge while busy, `cmp_above` is sampled against the trial code shown since the previous edge. If it is 1, the bit under test is cleared; if it is 0, the bit is kept. On the same edge the next lower bit is set. Bits above the tested one never change.
- R4: The WIDTH-th edge after the start edge decides bit 0 and raises `done` with `result`, so a conversion spans WIDTH+1 edges. `done` is low and `busy` high before that edge. With an ideal comparator (`cmp_above` = trial code greater than the input code), `result` equals the input code.
- R5: After completion `trial_code` returns to zero and `busy` falls. `done` and `result` then hold unchanged, whatever the comparator does, until a start is accepted.
- R6: `start` is ignored while busy: the conversion in progress continues with unchanged timing and result.
- R7: A comparator that always reports above yields result 0, and one that never does yields all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request level, sampled only when idle |
| cmp_above | input | 1 | Comparator: DAC output greater than analog input |
| trial_code | output | WIDTH | Code presented to the DAC |
| result | output | WIDTH | Last completed conversion |
| done | output | 1 | Result valid, held until the next accepted start |
| busy | output | 1 | Conversion in progress |

## Verification
The bench calls the edge that samples `start` edge 0. At edge 0 `trial_code` becomes the lone MSB. After edge j, for j from 1 to WIDTH-1, it holds the j decided upper bits plus the next trial bit. `done`, `result` and the zeroed trial code all appear after edge WIDTH. Every sample is taken at the falling edge that follows the edge in question, and that edge is counted explicitly, so an extra or missing register stage shows up as a mismatch. The hold checks idle for several cycles with a changed input and then compare `result` and `done` again. The busy-start checks inject a start pulse mid-conversion and still expect completion at edge WIDTH.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TEST = 1'b1
    } sar_state_e;
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last_bit,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy,
    output logic done
);
    sar_state_e state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start    ? ST_TEST : ST_IDLE;
            ST_TEST: nxt = last_bit ? ST_IDLE : ST_TEST;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        busy   = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_TEST: begin
                busy   = 1'b1;
                step   = 1'b1;
                finish = last_bit;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      done <= 1'b0;
        else if (finish) done <= 1'b1;
        else if (load)   done <= 1'b0;
    end
endmodule

// File: rtl/sar_pointer.sv
module sar_pointer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic [WIDTH-1:0] mask,
    output logic             last_bit
);
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mask <= '0;
        else if (load) mask <= TOP_ONE;
        else if (step) mask <= mask >> 1;
    end

    assign last_bit = mask[0];
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             last_bit,
    input  logic             cmp_above,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] decided;

    // per-bit decision: drop the tested bit when the DAC is above the input
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign decided[i] = trial[i] & ~(mask[i] & cmp_above);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial  <= '0;
            result <= '0;
        end else if (load) begin
            trial <= TOP_ONE;
        end else if (step) begin
            if (last_bit) begin
                result <= decided;
                trial  <= '0;
            end else begin
                trial <= decided | (mask >> 1);
            end
        end
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] trial_code,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic             busy
);
    logic             load, step, finish, last_bit;
    logic [WIDTH-1:0] mask;

    sar_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .last_bit (last_bit),
        .load     (load),
        .step     (step),
        .finish   (finish),
        .busy     (busy),
        .done     (done)
    );

    sar_pointer #(.WIDTH(WIDTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .mask     (mask),
        .last_bit (last_bit)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .last_bit  (last_bit),
        .cmp_above (cmp_above),
        .mask      (mask),
        .trial     (trial_code),
        .result    (result)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cmp_above,
    input logic [WIDTH-1:0] trial_code,
    input logic [WIDTH-1:0] result,
    input logic             done,
    input logic             busy
);
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    a_r2_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && trial_code == TOP_ONE));

    a_r3_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_above) |=>
            (!busy || ((trial_code & $past(trial_code)) == $past(trial_code))));

    a_r3_one_new_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($countones(trial_code ^ $past(trial_code)) <= 2));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (trial_code == '0));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !start) |=> (done && $stable(result)));

    a_r4_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_above;
    logic [W-1:0] trial_code, result;
    logic         done, busy;
    logic [W-1:0] vin = '0;
    int           mode = 0;   // 0 ideal, 1 always above, 2 never above
    int           n_chk = 0, n_bad = 0;
    bit           ended = 0;

    always #2.5 clk = ~clk;

    assign cmp_above = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : (trial_code > vin);

    sar_adc_ctrl #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .trial_code(trial_code), .result(result), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_result(input logic [W-1:0] v, input int m);
        if (m == 1) return '0;
        if (m == 2) return '1;
        return v;
    endfunction

    function automatic logic [W-1:0] exp_trial(input logic [W-1:0] v, input int j);
        logic [W-1:0] hi;
        hi = {W{1'b1}} << (W - j);
        return (v & hi) | (W'(1) << (W - 1 - j));
    endfunction

    task automatic convert(input logic [W-1:0] v, input int m, input int inject_at);
        @(negedge clk);
        vin = v; mode = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(trial_code == {1'b1, {(W-1){1'b0}}}, "R2 msb trial", trial_code, {1'b1, {(W-1){1'b0}}});
        chk(busy && !done, "R2 busy/done", {busy, done}, 2'b10);
        for (int j = 1; j < W; j++) begin
            @(posedge clk);
            @(negedge clk);
            start = (j == inject_at);  // R6 start while busy
            if (m == 0)
                chk(trial_code == exp_trial(v, j), "R3 trial step", trial_code, exp_trial(v, j));
            chk(!done && busy, "R4 not done early", {busy, done}, 2'b10);
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(done, "R4 done at edge W", done, 1);
        chk(result == exp_result(v, m), (m == 0) ? "R4 result" : "R7 stuck comparator",
            result, exp_result(v, m));
        chk(trial_code == '0 && !busy, "R5 trial cleared", trial_code, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #1;
        chk(trial_code == '0 && result == '0 && !done && !busy, "R1 reset",
            {trial_code, result, done, busy}, 0);
        #20 rst_n = 1'b1;
        @(negedge clk);
        chk(trial_code == '0 && !done && !busy, "R1 after release", {trial_code, done, busy}, 0);

        convert(8'h00, 0, 0);
        convert(8'hFF, 0, 0);
        convert(8'h80, 0, 0);
        convert(8'h7F, 0, 0);
        convert(8'h55, 0, 3);      // R6
        convert(8'hA3, 0, W - 1);  // R6 at last step
        convert(8'h3C, 1, 0);      // R7
        convert(8'h3C, 2, 0);      // R7

        // R5 hold with changed input and comparator
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            vin = W'($urandom); mode = k % 3;
        end
        chk(done && result == '1 && trial_code == '0, "R5 hold", result, '1);

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] r;
            r = W'($urandom);
            convert(r, 0, ((n % 4) == 0) ? 1 + (n % (W - 1)) : 0);
            repeat (n % 3) begin
                @(negedge clk);
                vin = W'($urandom);
            end
            @(negedge clk);
            chk(done && result == r, "R5 hold random", result, r);
        end

        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule